// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts events for a processor performance monitor. It has four 32-bit counters. Each counter has a 3-bit select code that picks one line of a 7-bit event pulse input. A code of zero leaves the counter idle. Two mode registers hold these select codes together with a global freeze bit, a freeze-on-interrupt option, a global interrupt enable and one overflow-enable bit per counter. A counter whose most significant bit is set counts as overflowed. When an enabled overflow appears, the block raises its interrupt request. On the cycle that request rises, it also captures the instruction address presented at its input.

Software reaches the state through a single-beat register port. A request is accepted every cycle it is valid, and the response comes back exactly one cycle later, so there is no back-pressure. Register addresses are 4 bits wide, and bit 3 chooses between the two windows:

| Address | Window | Contents |
|---|---|---|
| 0 to 3 | supervisor | counters 0 to 3 |
| 4 | supervisor | mode register A |
| 5 | supervisor | mode register B |
| 6 | supervisor | sampled instruction address |
| 7 | supervisor | sampled data address slot (not implemented) |
| 8 to 15 | user alias | the same slots as 0 to 7, read-only |

Field positions in mode register A:

| Bit(s) | Field |
|---|---|
| 31 | freeze |
| 30 | freeze on interrupt |
| 29 | interrupt enable |
| 11:9 | counter 1 select |
| 8:6 | counter 0 select |
| 3:0 | per-counter overflow enables (bit i for counter i) |

Field positions in mode register B:

| Bit(s) | Field |
|---|---|
| 5:3 | counter 3 select |
| 2:0 | counter 2 select |

Top module: `pmc_unit`

## Requirements
- R1: After reset, all counters, both mode registers and the sampled address read as zero, and `irq_o` is low.
- R2: When a counter's select code k is between 1 and 7, the counter rises by one on each cycle in which event bit k-1 is high and freeze is clear. A select code of 0 never counts.
- R3: While the freeze bit (mode A bit 31) is set, no counter changes except through a register write.
- R4: `irq_o` goes high one cycle after the following condition becomes true, and stays high while it holds: interrupt enable (mode A bit 29) is set, and some counter i has bit 31 set together with overflow enable bit i. A counter with its overflow enable clear never raises the request.
- R5: The sampled address takes the value of `iaddr_i` from the cycle before `irq_o` rises, and keeps it until the next rise or a supervisor write.
- R6: If freeze-on-interrupt (mode A bit 30) is set when `irq_o` rises, the freeze bit becomes set on that same edge.
- R7: A user read of address 8+n returns the same value as a supervisor read of address n, for n from 0 to 6.
- R8: Two kinds of request are violations: a user access (read or write) to addresses 0 to 6, and a write of any privilege to addresses 8 to 14. A violation sets `rsp_err_o` for its one response cycle, returns zero data and changes no state.
- R9: Writes to address 7 or 15 are accepted from either privilege without error and are discarded. Reads of these addresses return zero.
- R10: Supervisor writes load counters and mode registers. Mode bits that hold no field read back as zero, so writing all ones reads back 0xE0000FCF from mode A and 0x0000003F from mode B.
- R11: Each cycle with `req_valid_i` high gives exactly one cycle of `rsp_valid_o` on the following cycle, with read data in `rsp_rdata_o`. Idle cycles give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| ev_i | input | 7 | Event pulses, one bit per event source |
| iaddr_i | input | 32 | Address of the instruction currently executing |
| req_valid_i | input | 1 | Register request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_sup_i | input | 1 | 1 = supervisor privilege, 0 = user |
| req_addr_i | input | 4 | Register address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_rdata_o | output | 32 | Read data (zero for writes and violations) |
| rsp_err_o | output | 1 | Access violation for the previous request |
| irq_o | output | 1 | Performance monitor interrupt request |

## Verification
Most internal faults show at the ports within one or two cycles. A wrong select decode or a counter that advances while frozen is seen on the next read of that counter or of its user alias. A corrupted mode or overflow-enable bit changes `irq_o` one cycle after the affected counter's top bit sets. A capture that fires on the wrong cycle leaves a sampled address that differs from the address held before the rise, and a later change of `iaddr_i` exposes it on readback. Faults in the access decode show on the very response cycle, as a missing or spurious `rsp_err_o`, or as state altered by a request that should have been refused.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int NUM_CNT  = 4;
  localparam int SEL_W    = 3;
  localparam int NUM_EV   = (1 << SEL_W) - 1;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int SLOT_W   = ADDR_W - 1;

  typedef logic [DATA_W-1:0] word_t;

  // slot numbers inside a window; address bit SLOT_W picks the user alias
  localparam logic [SLOT_W-1:0] SLOT_MODEA = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_MODEB = 3'd5;
  localparam logic [SLOT_W-1:0] SLOT_SIA   = 3'd6;
  localparam logic [SLOT_W-1:0] SLOT_SDA   = 3'd7;

  // mode A fields
  localparam int MA_FRZ    = 31;
  localparam int MA_FOI    = 30;
  localparam int MA_IEN    = 29;
  localparam int MA_SEL_LO = 6;
  localparam int MA_OVF_LO = 0;
  // mode B fields
  localparam int MB_SEL_LO = 0;

  localparam word_t MA_MASK = word_t'(32'hE000_0FCF);
  localparam word_t MB_MASK = word_t'(32'h0000_003F);
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int SW  = SEL_W,
  parameter int NEV = (1 << SW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frz,
  input  logic [SW-1:0] sel,
  input  logic [NEV-1:0] ev,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  cnt
);
  logic [SW-1:0] idx;
  logic          hit;

  always_comb begin
    idx = sel - 1'b1;
    hit = (sel != '0) && ev[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (we)
      cnt <= wdata;
    else if (hit && !frz)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CNT-1:0]           cnt_msb,
  input  logic                         ma_we,
  input  logic                         mb_we,
  input  logic                         sia_we,
  input  word_t                        wdata,
  input  word_t                        iaddr,
  output word_t                        mode_a,
  output word_t                        mode_b,
  output word_t                        sia,
  output logic                         irq,
  output logic                         irq_cond,
  output logic                         irq_rise,
  output logic                         frz,
  output logic                         foi,
  output logic [NUM_CNT-1:0][SEL_W-1:0] sels
);
  localparam int SEL_IN_A = NUM_CNT / 2;

  word_t mode_a_n;

  always_comb begin
    frz      = mode_a[MA_FRZ];
    foi      = mode_a[MA_FOI];
    irq_cond = mode_a[MA_IEN] && |(mode_a[MA_OVF_LO +: NUM_CNT] & cnt_msb);
    irq_rise = irq_cond && !irq;
    mode_a_n = ma_we ? (wdata & MA_MASK) : mode_a;
    if (irq_rise && foi)
      mode_a_n[MA_FRZ] = 1'b1;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
    if (i < SEL_IN_A) begin : g_a
      assign sels[i] = mode_a[MA_SEL_LO + i*SEL_W +: SEL_W];
    end else begin : g_b
      assign sels[i] = mode_b[MB_SEL_LO + (i-SEL_IN_A)*SEL_W +: SEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_a <= '0;
      mode_b <= '0;
      sia    <= '0;
      irq    <= 1'b0;
    end else begin
      irq    <= irq_cond;
      mode_a <= mode_a_n;
      if (mb_we)
        mode_b <= wdata & MB_MASK;
      if (irq_rise)
        sia <= iaddr;
      else if (sia_we)
        sia <= wdata;
    end
  end
endmodule

// File: rtl/pmc_access.sv
module pmc_access
  import pmc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic                          req_sup,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_vals,
  input  word_t                         mode_a,
  input  word_t                         mode_b,
  input  word_t                         sia,
  output logic [NUM_CNT-1:0]            cnt_we,
  output logic                          ma_we,
  output logic                          mb_we,
  output logic                          sia_we,
  output logic                          rsp_valid,
  output word_t                         rsp_rdata,
  output logic                          rsp_err
);
  logic              is_alias;
  logic [SLOT_W-1:0] slot;
  logic              is_sda;
  logic              viol;
  logic              wr_ok;
  word_t             rd_val;

  always_comb begin
    is_alias = req_addr[SLOT_W];
    slot     = req_addr[SLOT_W-1:0];
    is_sda   = (slot == SLOT_SDA);
    viol     = req_valid && !is_sda &&
               ((is_alias && req_write) || (!is_alias && !req_sup));
    wr_ok    = req_valid && req_write && !viol && !is_alias;
    ma_we    = wr_ok && (slot == SLOT_MODEA);
    mb_we    = wr_ok && (slot == SLOT_MODEB);
    sia_we   = wr_ok && (slot == SLOT_SIA);
    rd_val   = '0;
    if (slot < SLOT_W'(NUM_CNT))
      rd_val = cnt_vals[slot[1:0]];
    else if (slot == SLOT_MODEA)
      rd_val = mode_a;
    else if (slot == SLOT_MODEB)
      rd_val = mode_b;
    else if (slot == SLOT_SIA)
      rd_val = sia;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_we
    assign cnt_we[i] = wr_ok && (slot == SLOT_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= viol;
      rsp_rdata <= (req_valid && !req_write && !viol) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/pmc_unit.sv
module pmc_unit
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic [DATA_W-1:0] iaddr_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_sup_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              irq_o
);
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_vals;
  logic [NUM_CNT-1:0][SEL_W-1:0]  sels;
  logic [NUM_CNT-1:0]             cnt_we;
  logic [NUM_CNT-1:0]             cnt_msb;
  logic                           ma_we, mb_we, sia_we;
  logic                           frz, foi, irq_cond, irq_rise;
  word_t                          mode_a, mode_b, sia;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pmc_counter #(.W(DATA_W), .SW(SEL_W), .NEV(NUM_EV)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .frz   (frz),
      .sel   (sels[i]),
      .ev    (ev_i),
      .we    (cnt_we[i]),
      .wdata (req_wdata_i),
      .cnt   (cnt_vals[i])
    );
    assign cnt_msb[i] = cnt_vals[i][DATA_W-1];
  end

  pmc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_msb  (cnt_msb),
    .ma_we    (ma_we),
    .mb_we    (mb_we),
    .sia_we   (sia_we),
    .wdata    (req_wdata_i),
    .iaddr    (iaddr_i),
    .mode_a   (mode_a),
    .mode_b   (mode_b),
    .sia      (sia),
    .irq      (irq_o),
    .irq_cond (irq_cond),
    .irq_rise (irq_rise),
    .frz      (frz),
    .foi      (foi),
    .sels     (sels)
  );

  pmc_access u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid_i),
    .req_write (req_write_i),
    .req_sup   (req_sup_i),
    .req_addr  (req_addr_i),
    .cnt_vals  (cnt_vals),
    .mode_a    (mode_a),
    .mode_b    (mode_b),
    .sia       (sia),
    .cnt_we    (cnt_we),
    .ma_we     (ma_we),
    .mb_we     (mb_we),
    .sia_we    (sia_we),
    .rsp_valid (rsp_valid_o),
    .rsp_rdata (rsp_rdata_o),
    .rsp_err   (rsp_err_o)
  );
endmodule

// File: rtl/pmc_unit_chk.sv
module pmc_unit_chk
  import pmc_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic                           req_valid_i,
  input logic                           rsp_valid_o,
  input logic                           rsp_err_o,
  input logic                           irq_o,
  input logic [DATA_W-1:0]              iaddr_i,
  input logic [DATA_W-1:0]              sia,
  input logic                           sia_we,
  input logic                           frz,
  input logic                           foi,
  input logic [NUM_CNT-1:0]             cnt_we,
  input logic [NUM_CNT-1:0][DATA_W-1:0] cnt_vals
);
  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o);

  p_no_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !rsp_valid_o);

  p_err_in_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_o |-> rsp_valid_o);

  p_sia_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (sia == $past(iaddr_i)));

  p_sia_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(irq_o) && !$past(sia_we)) |-> $stable(sia));

  p_freeze_on_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && $past(foi)) |-> frz);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_frz
    p_frozen_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(frz) && !$past(cnt_we[i])) |-> $stable(cnt_vals[i]));
  end
endmodule

bind pmc_unit pmc_unit_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .irq_o       (irq_o),
  .iaddr_i     (iaddr_i),
  .sia         (sia),
  .sia_we      (sia_we),
  .frz         (frz),
  .foi         (foi),
  .cnt_we      (cnt_we),
  .cnt_vals    (cnt_vals)
);

// File: tb/pmc_unit_tb_top.sv
`timescale 1ns/1ps
module pmc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  ev_i = '0;
  logic [31:0] iaddr_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic        req_sup_i = 1'b0;
  logic [3:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic        rsp_err_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pmc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .iaddr_i(iaddr_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_sup_i(req_sup_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one register request; response sampled at the following negedge
  task automatic acc(input logic wr, input logic sup, input logic [3:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_sup_i = sup;
    req_addr_i = a; req_wdata_i = d;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R11 rsp_valid", {31'b0, rsp_valid_o}, 32'd1);
    rd = rsp_rdata_o;
    er = rsp_err_o;
  endtask

  task automatic swr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    acc(1'b1, 1'b1, a, d, rd, er);
  endtask

  task automatic srd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic er;
    acc(1'b0, 1'b1, a, 32'h0, rd, er);
    chk(req, rd, exp);
  endtask

  task automatic pulse(input logic [6:0] e, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ev_i = e;
    end
    @(negedge clk); ev_i = '0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 7; a++) srd_chk("R1 reset value", 4'(a), 32'h0);
    chk("R1 irq after reset", {31'b0, irq_o}, 32'd0);
    @(negedge clk);
    chk("R11 idle no rsp", {31'b0, rsp_valid_o}, 32'd0);
  endtask

  task automatic t_count();
    swr(4'd4, 32'h0000_0040);   // counter0 select 1
    swr(4'd5, 32'h0000_001F);   // counter2 select 7, counter3 select 3
    pulse(7'b0000001, 3);
    pulse(7'b1000000, 2);
    pulse(7'b0000100, 1);
    srd_chk("R2 cnt0 code1", 4'd0, 32'd3);
    srd_chk("R2 cnt1 code0 holds", 4'd1, 32'd0);
    srd_chk("R2 cnt2 code7", 4'd2, 32'd2);
    srd_chk("R2 cnt3 code3", 4'd3, 32'd1);
  endtask

  task automatic t_freeze();
    swr(4'd4, 32'h8000_0040);
    pulse(7'b1111111, 4);
    srd_chk("R3 frozen cnt0", 4'd0, 32'd3);
    srd_chk("R3 frozen cnt2", 4'd2, 32'd2);
    swr(4'd4, 32'h0);
    swr(4'd5, 32'h0);
  endtask

  task automatic t_alias();
    logic [31:0] rs, ru; logic er;
    swr(4'd6, 32'hCAFE_0006);
    swr(4'd5, 32'h0000_0012);
    for (int n = 0; n < 7; n++) begin
      acc(1'b0, 1'b1, 4'(n), 32'h0, rs, er);
      acc(1'b0, 1'b0, 4'(n + 8), 32'h0, ru, er);
      chk("R7 alias matches", ru, rs);
      chk("R7 alias no error", {31'b0, er}, 32'd0);
    end
    swr(4'd5, 32'h0);
  endtask

  task automatic t_violation();
    logic [31:0] rd; logic er;
    acc(1'b0, 1'b0, 4'd0, 32'h0, rd, er);
    chk("R8 user read sup err", {31'b0, er}, 32'd1);
    chk("R8 user read sup data", rd, 32'h0);
    @(negedge clk);
    chk("R8 err one cycle", {31'b0, rsp_err_o}, 32'd0);
    acc(1'b1, 1'b0, 4'd4, 32'hFFFF_FFFF, rd, er);
    chk("R8 user write sup err", {31'b0, er}, 32'd1);
    srd_chk("R8 modeA untouched", 4'd4, 32'h0);
    acc(1'b1, 1'b1, 4'd9, 32'h1234_5678, rd, er);
    chk("R8 alias write err", {31'b0, er}, 32'd1);
    srd_chk("R8 cnt1 untouched", 4'd1, 32'h0);
  endtask

  task automatic t_sda();
    logic [31:0] rd; logic er;
    acc(1'b1, 1'b0, 4'd7, 32'hDEAD_BEEF, rd, er);
    chk("R9 user write slot7 ok", {31'b0, er}, 32'd0);
    acc(1'b1, 1'b0, 4'd15, 32'hDEAD_BEEF, rd, er);
    chk("R9 user write slot15 ok", {31'b0, er}, 32'd0);
    acc(1'b1, 1'b1, 4'd7, 32'hDEAD_BEEF, rd, er);
    chk("R9 sup write slot7 ok", {31'b0, er}, 32'd0);
    srd_chk("R9 slot7 reads zero", 4'd7, 32'h0);
    acc(1'b0, 1'b0, 4'd15, 32'h0, rd, er);
    chk("R9 slot15 reads zero", rd, 32'h0);
    srd_chk("R9 cnt0 unchanged", 4'd0, 32'd3);
    srd_chk("R9 sia unchanged", 4'd6, 32'hCAFE_0006);
  endtask

  task automatic t_mode_rw();
    swr(4'd4, 32'hFFFF_FFFF);
    swr(4'd5, 32'hFFFF_FFFF);
    srd_chk("R10 modeA mask", 4'd4, 32'hE000_0FCF);
    srd_chk("R10 modeB mask", 4'd5, 32'h0000_003F);
    swr(4'd4, 32'h0);
    swr(4'd5, 32'h0);
    swr(4'd3, 32'h0000_00A5);
    srd_chk("R10 cnt3 write", 4'd3, 32'h0000_00A5);
  endtask

  task automatic t_irq();
    swr(4'd0, 32'h7FFF_FFFF);
    swr(4'd4, 32'h6000_0041);   // ien, freeze-on-irq, ovf en0, sel0=1
    iaddr_i = 32'h0000_1000;
    @(negedge clk); ev_i = 7'b0000001;
    @(negedge clk); ev_i = '0;
    chk("R4 irq not yet", {31'b0, irq_o}, 32'd0);
    @(negedge clk);
    chk("R4 irq raised", {31'b0, irq_o}, 32'd1);
    iaddr_i = 32'h0000_2000;
    srd_chk("R5 sia captured", 4'd6, 32'h0000_1000);
    srd_chk("R6 freeze set", 4'd4, 32'hE000_0041);
    pulse(7'b0000001, 3);
    srd_chk("R3 frozen after irq", 4'd0, 32'h8000_0000);
    chk("R4 irq held", {31'b0, irq_o}, 32'd1);
    srd_chk("R5 sia holds", 4'd6, 32'h0000_1000);
    swr(4'd0, 32'h0);
    @(negedge clk);
    chk("R4 irq drops", {31'b0, irq_o}, 32'd0);
    swr(4'd4, 32'h2000_0040);   // ien only, overflow enable clear
    swr(4'd0, 32'h8000_0000);
    @(negedge clk); @(negedge clk);
    chk("R4 disabled overflow no irq", {31'b0, irq_o}, 32'd0);
    srd_chk("R5 sia no new capture", 4'd6, 32'h0000_1000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_freeze();
    t_alias();
    t_violation();
    t_sda();
    t_mode_rw();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule